// File: doc/BRIEF.md
# Multi-Channel Reload Timer Unit

The unit puts two or three independent down-counting reload timers behind one word-addressed register window. A single start register runs and pauses the channels one bit per channel. Each channel has its own reload value, live count and control word, and raises its own interrupt line when its count passes zero and the interrupt is enabled. A build parameter drops the third channel. A second build parameter drops the one-bit output-control register at the bottom of the window.

All channels take their count ticks from one shared free-running prescaler. Each channel picks one of five tap ratios with its own select field. Reads return registered data one cycle after the request. An access to a hole in the window raises an error pulse. In a two-channel build, a write that tries to start the missing channel also raises the error pulse.

Top module: `multi_timer_unit`

## Requirements
- R1: After reset the start register and output-control register read 0, every reload and count register reads 0xFFFFFFFF, every control word reads 0, and all interrupt outputs are low.
- R2: The window is decoded on address bits [7:2], and address bits [1:0] are ignored. 0x00 is output control and 0x04 is start. Channel k owns three words from byte 0x08 + 12*k: reload at +0, count at +4 and control at +8. This places the channels at 0x08, 0x14 and 0x20.
- R3: Start bit k runs channel k from the cycle after the write. Reading 0x04 returns the stored start bits of the built channels.
- R4: A shared prescaler counter P is cleared by reset and advances every cycle. A running channel with divisor D acts on the edges where P mod D equals D-1. On such an edge it decrements its count. If the count is 0 at that edge, it loads its reload value instead and sets its underflow flag.
- R5: While its start bit is 0 a channel holds its count. Setting the bit again resumes counting from the held value.
- R6: Control word fields: bits [2:0] select D. Values 0, 1, 2, 3 and 4 give 4, 16, 64, 256 and 1024, and values 5 to 7 give 1024. Bit 5 enables the interrupt and bit 8 is the underflow flag. A control write with bit 8 = 0 clears the flag and one with bit 8 = 1 leaves it unchanged. An underflow in the same cycle as a control write leaves the flag set.
- R7: Interrupt output k equals (flag AND enable) of channel k as registered one cycle earlier. Bit 2 is always 0 in a two-channel build.
- R8: An error pulse appears one cycle after any of the following: a read or write to a word index of 11 or above; a read or write to channel 2 words in a two-channel build; a read or write to 0x00 when the output-control register is absent; a start write with bit 2 set in a two-channel build. A read of an undefined word returns 0.
- R9: The output-control register stores only bit 0 of the written data.
- R10: Read data is registered. It shows the addressed value as it stood at the read edge, and it holds until the next read.
- R11: A write to a channel's count takes priority over a tick at the same edge. The written value is stored and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle pulse for an undefined access |
| timer_irq | output | 3 | Per-channel interrupt lines |

## Verification
The hardest case to reach is an underflow that lands on the same edge as a control write that clears the flag. The ticks come from a shared prescaler whose phase is not visible, so the bench does not try to aim at that edge. It sets a channel to reload 0 at the fastest divisor, so it underflows every fourth cycle, and then issues flag-clearing control writes on every consecutive cycle. Some of those writes must coincide with an underflow. Count writes that collide with ticks are produced the same way. A second two-channel, no-output-control instance covers the error cases that only that build has.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  localparam int MAX_CH       = 3;
  localparam int WORD_OCTL    = 0;
  localparam int WORD_START   = 1;
  localparam int WORD_CH_BASE = 2;
  localparam int REGS_PER_CH  = 3;
  localparam int SEL_W        = 3;
  localparam int IE_BIT       = 5;
  localparam int FLAG_BIT     = 8;

  typedef enum logic [1:0] {
    CR_RELOAD = 2'd0,
    CR_COUNT  = 2'd1,
    CR_CTRL   = 2'd2,
    CR_NONE   = 2'd3
  } ch_reg_e;
endpackage

// File: rtl/mtu_prescale.sv
module mtu_prescale #(
  parameter int NUM_DIV = 5
) (
  input  logic               clk,
  input  logic               rst,
  output logic [NUM_DIV-1:0] ticks
);
  localparam int PRE_W = 2 * NUM_DIV;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
    assign ticks[k] = &pre_q[2*k+1:0];
  end

  // R4: a slower tap only fires together with the fastest one
  assert_tick_nest_R4: assert property (@(posedge clk) disable iff (rst)
    ticks[NUM_DIV-1] |-> ticks[0]);
  // R4: the fastest tap never fires on two edges in a row
  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
    ticks[0] |=> !ticks[0]);
endmodule

// File: rtl/mtu_decode.sv
module mtu_decode
  import mtu_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_CH   = 3,
  parameter bit HAS_OCTL = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_octl,
  output logic              hit_start,
  output logic [NUM_CH-1:0] ch_hit,
  output ch_reg_e           ch_reg,
  output logic              valid
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    hit_octl  = HAS_OCTL && (int'(word) == WORD_OCTL);
    hit_start = (int'(word) == WORD_START);
    ch_hit    = '0;
    ch_reg    = CR_NONE;
    for (int k = 0; k < NUM_CH; k++) begin
      if (int'(word) >= WORD_CH_BASE + REGS_PER_CH * k &&
          int'(word) <  WORD_CH_BASE + REGS_PER_CH * (k + 1)) begin
        ch_hit[k] = 1'b1;
        ch_reg    = ch_reg_e'(2'(int'(word) - WORD_CH_BASE - REGS_PER_CH * k));
      end
    end
    valid = hit_octl | hit_start | (|ch_hit);
  end
endmodule

// File: rtl/mtu_channel.sv
module mtu_channel
  import mtu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int NUM_DIV = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [NUM_DIV-1:0] ticks,
  input  logic               wr_en,
  input  ch_reg_e            reg_sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rd_val,
  output logic               irq
);
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             ie_q, flag_q;
  logic             wr_reload, wr_cnt, wr_ctrl, tick, step, underflow;
  int               sel_idx;

  assign wr_reload = wr_en && (reg_sel == CR_RELOAD);
  assign wr_cnt    = wr_en && (reg_sel == CR_COUNT);
  assign wr_ctrl   = wr_en && (reg_sel == CR_CTRL);

  always_comb begin
    sel_idx = (int'(sel_q) >= NUM_DIV) ? NUM_DIV - 1 : int'(sel_q);
    tick    = ticks[sel_idx];
  end

  assign step      = run && tick;
  assign underflow = step && (cnt_q == '0) && !wr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      cnt_q    <= '1;
      sel_q    <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= flag_q & ie_q;
      if (wr_reload) reload_q <= wdata[CNT_W-1:0];
      if (wr_cnt)         cnt_q <= wdata[CNT_W-1:0];
      else if (underflow) cnt_q <= reload_q;
      else if (step)      cnt_q <= cnt_q - 1'b1;
      if (wr_ctrl) begin
        sel_q <= wdata[SEL_W-1:0];
        ie_q  <= wdata[IE_BIT];
      end
      flag_q <= underflow | (wr_ctrl ? (flag_q & wdata[FLAG_BIT]) : flag_q);
    end
  end

  always_comb begin
    rd_val = '0;
    case (reg_sel)
      CR_RELOAD: rd_val[CNT_W-1:0] = reload_q;
      CR_COUNT:  rd_val[CNT_W-1:0] = cnt_q;
      CR_CTRL: begin
        rd_val[SEL_W-1:0] = sel_q;
        rd_val[IE_BIT]    = ie_q;
        rd_val[FLAG_BIT]  = flag_q;
      end
      default:   rd_val = '0;
    endcase
  end

  // R5: a paused channel with no count write keeps its count
  assert_hold_paused_R5: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_cnt) |=> $stable(cnt_q));
  // R4: passing zero loads the reload value
  assert_reload_on_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt_q == '0 && !wr_cnt) |=> (cnt_q == $past(reload_q)));
  // R6: underflow beats a clearing control write
  assert_flag_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt_q == '0 && !wr_cnt) |=> flag_q);
  // R7: the flag only rises while running
  assert_flag_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(run));
  // R7: no interrupt unless it was enabled
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie_q));
endmodule

// File: rtl/multi_timer_unit.sv
module multi_timer_unit
  import mtu_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int NUM_DIV  = 5,
  parameter bit THREE_CH = 1'b1,
  parameter bit HAS_OCTL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic [MAX_CH-1:0] timer_irq
);
  localparam int NUM_CH = THREE_CH ? 3 : 2;
  localparam logic [MAX_CH-1:0] START_MASK = MAX_CH'((1 << NUM_CH) - 1);

  logic               hit_octl, hit_start, dec_valid;
  logic [NUM_CH-1:0]  ch_hit, ch_irq, start_q;
  ch_reg_e            ch_reg;
  logic [NUM_DIV-1:0] ticks;
  logic [DATA_W-1:0]  ch_rd [NUM_CH];
  logic [DATA_W-1:0]  rd_mux;
  logic               octl_q, access, bad_start;

  mtu_prescale #(.NUM_DIV(NUM_DIV)) u_pre (
    .clk(clk), .rst(rst), .ticks(ticks)
  );

  mtu_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .HAS_OCTL(HAS_OCTL)) u_dec (
    .addr(bus_addr), .hit_octl(hit_octl), .hit_start(hit_start),
    .ch_hit(ch_hit), .ch_reg(ch_reg), .valid(dec_valid)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    mtu_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_DIV(NUM_DIV)) u_ch (
      .clk(clk), .rst(rst), .run(start_q[k]), .ticks(ticks),
      .wr_en(bus_wr && ch_hit[k]), .reg_sel(ch_reg), .wdata(bus_wdata),
      .rd_val(ch_rd[k]), .irq(ch_irq[k])
    );
  end

  for (genvar k = 0; k < MAX_CH; k++) begin : g_irq
    if (k < NUM_CH) begin : g_on
      assign timer_irq[k] = ch_irq[k];
    end else begin : g_off
      assign timer_irq[k] = 1'b0;
    end
  end

  assign access    = bus_wr | bus_rd;
  assign bad_start = bus_wr && hit_start && (|(bus_wdata[MAX_CH-1:0] & ~START_MASK));

  always_comb begin
    rd_mux = '0;
    if (hit_octl)  rd_mux[0] = octl_q;
    if (hit_start) rd_mux[NUM_CH-1:0] = start_q;
    for (int k = 0; k < NUM_CH; k++)
      if (ch_hit[k]) rd_mux = ch_rd[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= '0;
      octl_q    <= 1'b0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      if (bus_wr && hit_start) start_q <= bus_wdata[NUM_CH-1:0];
      if (bus_wr && hit_octl)  octl_q  <= bus_wdata[0];
      if (bus_rd)              bus_rdata <= rd_mux;
      bus_err <= (access && !dec_valid) || bad_start;
    end
  end

  // R8: an error pulse always follows an access
  assert_err_after_access_R8: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_wr || bus_rd));
  // R8: starting a missing channel is reported
  assert_start_missing_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(WORD_START) && !THREE_CH && bus_wdata[2])
      |=> bus_err);
  // R10: read data only changes after a read
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R3: start register changes only on a start write
  assert_start_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && hit_start) |=> $stable(start_q));
endmodule

// File: tb/multi_timer_unit_tb.sv
module multi_timer_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [2:0]  irq;

  logic        w2 = 1'b0, r2 = 1'b0;
  logic [7:0]  a2 = '0;
  logic [31:0] d2 = '0;
  logic [31:0] rdata2;
  logic        err2;
  logic [2:0]  irq2;

  int total = 0;
  int bad = 0;
  string rd_tag = "R1";

  always #4 clk = ~clk;

  multi_timer_unit u_dut (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err), .timer_irq(irq)
  );

  multi_timer_unit #(.THREE_CH(1'b0), .HAS_OCTL(1'b0)) u_dut_two (
    .clk(clk), .rst(rst), .bus_wr(w2), .bus_rd(r2), .bus_addr(a2),
    .bus_wdata(d2), .bus_rdata(rdata2), .bus_err(err2), .timer_irq(irq2)
  );

  // behavioural reference of the three-channel build
  int unsigned m_rl [3];
  int unsigned m_cn [3];
  int unsigned m_sel [3];
  bit          m_ie [3];
  bit          m_fl [3];
  bit [2:0]    m_irq;
  bit [2:0]    m_start;
  bit          m_octl;
  longint      pcnt;
  bit [31:0]   m_rdata;
  bit          m_err;

  function automatic int unsigned divisor(int unsigned s);
    return (s >= 4) ? 1024 : (4 << (2 * s));
  endfunction

  function automatic bit [31:0] m_read(int word);
    if (word == 0) return {31'd0, m_octl};
    if (word == 1) return {29'd0, m_start};
    for (int k = 0; k < 3; k++) begin
      if (word == 2 + 3 * k)     return m_rl[k];
      if (word == 3 + 3 * k)     return m_cn[k];
      if (word == 4 + 3 * k)     return (32'(m_fl[k]) << 8) | (32'(m_ie[k]) << 5) | m_sel[k];
    end
    return 32'd0;
  endfunction

  always @(posedge clk) begin : model
    int  word;
    bit  tick, wc, uf;
    word = int'(addr) / 4;
    if (rst) begin
      for (int k = 0; k < 3; k++) begin
        m_rl[k] = 32'hFFFF_FFFF; m_cn[k] = 32'hFFFF_FFFF;
        m_sel[k] = 0; m_ie[k] = 0; m_fl[k] = 0;
      end
      m_irq = '0; m_start = '0; m_octl = 0; pcnt = 0; m_rdata = '0; m_err = 0;
    end else begin
      if (rd) m_rdata = m_read(word);
      m_err = (rd || wr) && (word > 10);
      for (int k = 0; k < 3; k++) begin
        m_irq[k] = m_fl[k] & m_ie[k];
        tick = m_start[k] && ((pcnt % divisor(m_sel[k])) == divisor(m_sel[k]) - 1);
        wc = wr && word == 3 + 3 * k;
        uf = tick && !wc && m_cn[k] == 0;
        if (wc)        m_cn[k] = wdata;
        else if (uf)   m_cn[k] = m_rl[k];
        else if (tick) m_cn[k] = m_cn[k] - 1;
        if (wr && word == 2 + 3 * k) m_rl[k] = wdata;
        if (wr && word == 4 + 3 * k) begin
          m_sel[k] = wdata[2:0];
          m_ie[k]  = wdata[5];
          m_fl[k]  = uf | (m_fl[k] & wdata[8]);
        end else if (uf) m_fl[k] = 1'b1;
      end
      if (wr && word == 1) m_start = wdata[2:0];
      if (wr && word == 0) m_octl = wdata[0];
      pcnt++;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(irq === m_irq, "R7 irq", 32'(irq), 32'(m_irq));
      chk(err === m_err, "R8 err", 32'(err), 32'(m_err));
      chk(rdata === m_rdata, rd_tag, rdata, m_rdata);
    end
  end

  task automatic acc(bit w, bit r, logic [7:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wr = 1'b0; rd = 1'b0;
    rd_tag = tag;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic acc2(bit w, bit r, logic [7:0] a, logic [31:0] d,
                      bit exp_err, string tag);
    @(negedge clk);
    w2 = w; r2 = r; a2 = a; d2 = d;
    @(posedge clk);
    #1;
    w2 = 1'b0; r2 = 1'b0;
    @(negedge clk);
    chk(err2 === exp_err, tag, 32'(err2), 32'(exp_err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(4);
    @(negedge clk) rst = 1'b0;
    // R1 reset values
    foreach (addr_list_r1[i]) acc(0, 1, addr_list_r1[i], 0, "R1");
    // R2 low address bits ignored
    acc(0, 1, 8'h0B, 0, "R2"); acc(0, 1, 8'h17, 0, "R2"); acc(0, 1, 8'h2A, 0, "R2");
    // R9 output control keeps bit 0
    acc(1, 0, 8'h00, 32'hFFFF_FFFE, "R9"); acc(0, 1, 8'h00, 0, "R9");
    acc(1, 0, 8'h00, 32'h0000_0003, "R9"); acc(0, 1, 8'h00, 0, "R9");
    // channel setup
    acc(1, 0, 8'h08, 5, "R2"); acc(1, 0, 8'h0C, 3, "R2"); acc(1, 0, 8'h10, 32'h20, "R6");
    acc(1, 0, 8'h14, 2, "R2"); acc(1, 0, 8'h18, 2, "R2"); acc(1, 0, 8'h1C, 32'h21, "R6");
    acc(1, 0, 8'h20, 1, "R2"); acc(1, 0, 8'h24, 0, "R2"); acc(1, 0, 8'h28, 32'h22, "R6");
    acc(1, 0, 8'h04, 7, "R3"); acc(0, 1, 8'h04, 0, "R3");
    // R4 counting and reload
    for (int i = 0; i < 40; i++) begin
      idle(5);
      acc(0, 1, 8'h0C, 0, "R4"); acc(0, 1, 8'h18, 0, "R4"); acc(0, 1, 8'h24, 0, "R4");
    end
    // R5 pause and resume channel 1
    acc(1, 0, 8'h04, 5, "R5"); acc(0, 1, 8'h18, 0, "R5");
    idle(100); acc(0, 1, 8'h18, 0, "R5");
    acc(1, 0, 8'h04, 7, "R5"); idle(40); acc(0, 1, 8'h18, 0, "R5");
    // R6 flag keep and clear
    acc(0, 1, 8'h10, 0, "R6"); acc(1, 0, 8'h10, 32'h120, "R6"); acc(0, 1, 8'h10, 0, "R6");
    acc(1, 0, 8'h10, 32'h020, "R6"); acc(0, 1, 8'h10, 0, "R6");
    acc(1, 0, 8'h08, 0, "R6"); acc(1, 0, 8'h0C, 0, "R6");
    for (int i = 0; i < 30; i++) acc(1, 0, 8'h10, 32'h020, "R6");
    acc(0, 1, 8'h10, 0, "R6");
    // R7 interrupt disabled channel stays quiet
    acc(1, 0, 8'h10, 32'h000, "R7"); idle(30); acc(0, 1, 8'h10, 0, "R7");
    acc(1, 0, 8'h10, 32'h020, "R7");
    // R11 count writes collide with ticks
    for (int i = 0; i < 30; i++) acc(1, 0, 8'h0C, 0, "R11");
    acc(0, 1, 8'h0C, 0, "R11"); acc(0, 1, 8'h10, 0, "R11");
    // R6 slow selects
    acc(1, 0, 8'h1C, 32'h23, "R6"); acc(1, 0, 8'h18, 1, "R6");
    acc(1, 0, 8'h28, 32'h24, "R6"); acc(1, 0, 8'h24, 2, "R6");
    for (int i = 0; i < 12; i++) begin
      idle(250); acc(0, 1, 8'h18, 0, "R6"); acc(0, 1, 8'h24, 0, "R6");
    end
    acc(1, 0, 8'h28, 32'h27, "R6"); acc(1, 0, 8'h24, 1, "R6");
    for (int i = 0; i < 9; i++) begin
      idle(250); acc(0, 1, 8'h24, 0, "R6"); acc(0, 1, 8'h28, 0, "R6");
    end
    // R8 holes in the window
    acc(0, 1, 8'h2C, 0, "R8"); acc(1, 0, 8'h30, 32'h55, "R8");
    acc(0, 1, 8'hFC, 0, "R8"); acc(0, 1, 8'h00, 0, "R8");
    // R10 read data holds while idle
    acc(0, 1, 8'h08, 0, "R10"); idle(20);
    acc(1, 0, 8'h04, 0, "R3"); idle(20);
    // two-channel build without output control
    acc2(1, 0, 8'h04, 32'h7, 1'b1, "R8 start bit 2");
    acc2(0, 1, 8'h04, 0, 1'b0, "R8 start read");
    chk(rdata2 === 32'h3, "R3 two-channel start readback", rdata2, 32'h3);
    acc2(0, 1, 8'h20, 0, 1'b1, "R8 channel 2 absent");
    acc2(1, 0, 8'h28, 0, 1'b1, "R8 channel 2 absent");
    acc2(0, 1, 8'h00, 0, 1'b1, "R8 output control absent");
    acc2(0, 1, 8'h1C, 0, 1'b0, "R8 channel 1 control");
    chk(rdata2 === 32'h0, "R1 two-channel control", rdata2, 32'h0);
    chk(irq2[2] === 1'b0, "R7 two-channel irq 2", 32'(irq2[2]), 32'h0);
    idle(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [7:0] addr_list_r1 [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10,
                                    8'h14, 8'h1C, 8'h20, 8'h24, 8'h28};
endmodule